// File: doc/BRIEF.md
# Serial Frame Transmitter with Command Edge Shaping

This block turns one parallel byte into an asynchronous serial frame on a single output line. A frame has a low start bit, the eight data bits with the least significant bit first, an even parity bit, and a high stop bit. Every bit is held on the line for a fixed number of pulses of an oversampling clock enable. By default the enable runs at sixteen times the baud rate and each bit lasts sixteen pulses. Clock cycles without an enable pulse do not advance the bit timing.

The transmit command may come from logic whose pulse width cannot be bounded. The block therefore reacts only to a low-to-high change of the command, seen in the idle state. A command held high for any length of time produces exactly one frame. The word is captured into an internal buffer when the command is accepted. A busy output covers the whole frame, and commands that arrive during a frame are ignored.

Top module: `serial_frame_tx`

## Requirements
- R1: While reset is high, and afterwards until a command is accepted, txLine is 1 and busy is 0.
- R2: In idle, a rising edge of sendCmd (high this cycle, low the cycle before) is accepted at the next clock edge. At that same edge busy goes to 1 and txLine goes to 0, which begins the start bit.
- R3: Each bit of the frame stays on txLine for exactly 16 tickEn pulses (OVERSAMPLE). Cycles with tickEn low leave txLine unchanged. The line moves to the next bit at the clock edge that counts the 16th pulse.
- R4: The frame order on txLine is: start bit 0, then dataIn[0] through dataIn[7], then the parity bit, then stop bit 1.
- R5: The parity bit is even parity: it equals the XOR of the eight data bits, so each frame carries an even number of ones across data and parity.
- R6: The word sent is dataIn as sampled at the accepting edge. Changes to dataIn after that edge have no effect on the frame in progress.
- R7: A sendCmd held high through and past the end of a frame starts no second frame. A new frame needs sendCmd to be low for at least one cycle and then high again.
- R8: Rising edges of sendCmd while busy is 1 are ignored. The frame in progress continues unchanged, and no frame follows it.
- R9: busy returns to 0 at the edge that ends the stop bit, with txLine at 1. A rising edge of sendCmd in the very next cycle starts a new frame.
- R10: A sendCmd that is already high when reset is released does not start a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tickEn | input | 1 | Oversampling enable, one pulse per sixteenth of a bit time |
| dataIn | input | 8 | Parallel word to transmit, sampled when a command is accepted |
| sendCmd | input | 1 | Transmit command of any width; only its rising edge in idle counts |
| txLine | output | 1 | Serial output, high when idle |
| busy | output | 1 | High from command acceptance until the stop bit ends |

## Verification
The bench builds the block with its default values: eight data bits and sixteen enable pulses per bit. The full eleven-bit frame, including parity, is therefore checked bit by bit at the exact pulse count where each bit begins and ends. The enable is run every cycle, every third cycle and every fifth cycle. This shows that the bit timing follows the enable pulses and not the clock. With these defaults a frame is short enough for the bench to also hold the command high past a frame end, to issue commands in the middle of a frame, and to send frames back to back.

// File: rtl/sftx_pkg.sv
package sftx_pkg;

  // Frame sequencer states; the data phase stays in stWait and moves bits via a shift strobe
  typedef enum logic [1:0] {
    stIdle  = 2'd0,
    stStart = 2'd1,
    stWait  = 2'd2,
    stStop  = 2'd3
  } txState_t;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic load;   // capture word and parity, drive start bit
    logic shift;  // put next buffered bit on the line
    logic stop;   // drive stop bit
  } dpStrobe_t;

endpackage

// File: rtl/sftx_ctrl.sv
module sftx_ctrl
  import sftx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tickEn,
  input  logic      sendCmd,
  output dpStrobe_t strobe,
  output logic      busy
);

  localparam int SHIFT_BITS = DATA_W + 1;  // data bits plus parity
  localparam int CNT_W      = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  localparam int BIT_W      = $clog2(SHIFT_BITS + 1);

  txState_t         state, nextState;
  logic             cmdPrev;
  logic             cmdPulse;
  logic [CNT_W-1:0] tickCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             bitEnd;
  logic             lastShift;

  // A command counts only on its rising edge
  assign cmdPulse  = sendCmd & ~cmdPrev;
  assign bitEnd    = tickEn && (tickCnt == CNT_W'(OVERSAMPLE - 1));
  assign lastShift = (bitCnt == BIT_W'(SHIFT_BITS));

  always_comb begin
    nextState = state;
    strobe    = '0;
    case (state)
      stIdle: begin
        if (cmdPulse) begin
          strobe.load = 1'b1;
          nextState   = stStart;
        end
      end
      stStart: begin
        if (bitEnd) begin
          strobe.shift = 1'b1;
          nextState    = stWait;
        end
      end
      stWait: begin
        if (bitEnd) begin
          if (lastShift) begin
            strobe.stop = 1'b1;
            nextState   = stStop;
          end else begin
            strobe.shift = 1'b1;
          end
        end
      end
      stStop: begin
        if (bitEnd) nextState = stIdle;
      end
      default: nextState = stIdle;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= stIdle;
      cmdPrev <= 1'b1;  // a level present at reset release is not an edge
      tickCnt <= '0;
      bitCnt  <= '0;
    end else begin
      state   <= nextState;
      cmdPrev <= sendCmd;
      if (state == stIdle) begin
        tickCnt <= '0;
      end else if (tickEn) begin
        tickCnt <= bitEnd ? '0 : tickCnt + 1'b1;
      end
      if (strobe.load) begin
        bitCnt <= '0;
      end else if (strobe.shift) begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  assign busy = (state != stIdle);

endmodule

// File: rtl/sftx_dpath.sv
module sftx_dpath
  import sftx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] dataIn,
  output logic              txLine
);

  localparam int SHIFT_BITS = DATA_W + 1;

  logic [SHIFT_BITS-1:0] shiftBuf;
  logic                  parityBit;
  logic                  txReg;

  // Even parity over the captured word
  assign parityBit = ^dataIn;

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftBuf <= '0;
      txReg    <= 1'b1;
    end else if (strobe.load) begin
      shiftBuf <= {parityBit, dataIn};
      txReg    <= 1'b0;
    end else if (strobe.shift) begin
      txReg    <= shiftBuf[0];
      shiftBuf <= shiftBuf >> 1;
    end else if (strobe.stop) begin
      txReg    <= 1'b1;
    end
  end

  assign txLine = txReg;

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import sftx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tickEn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              sendCmd,
  output logic              txLine,
  output logic              busy
);

  dpStrobe_t strobe;

  sftx_ctrl #(
    .DATA_W    (DATA_W),
    .OVERSAMPLE(OVERSAMPLE)
  ) uCtrl (
    .clk    (clk),
    .rst    (rst),
    .tickEn (tickEn),
    .sendCmd(sendCmd),
    .strobe (strobe),
    .busy   (busy)
  );

  sftx_dpath #(
    .DATA_W(DATA_W)
  ) uDpath (
    .clk   (clk),
    .rst   (rst),
    .strobe(strobe),
    .dataIn(dataIn),
    .txLine(txLine)
  );

endmodule

// File: rtl/sftx_chk.sv
module sftx_chk (
  input logic clk,
  input logic rst,
  input logic tickEn,
  input logic sendCmd,
  input logic txLine,
  input logic busy
);

  // R1: the line rests high whenever no frame is running
  a_r1_idle_high: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txLine);

  // R2: acceptance raises busy and opens the start bit
  a_r2_start_low: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !txLine);

  // R2: a rising command edge in idle is taken at the next edge
  a_r2_accept: assert property (@(posedge clk) disable iff (rst)
    (!busy && sendCmd && !$past(sendCmd)) |=> busy);

  // R3: the line moves only on edges that carried a tick
  a_r3_tick_only: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && !$past(tickEn)) |-> $stable(txLine));

  // R9: a frame always ends on the high stop level
  a_r9_stop_high: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> txLine);

endmodule

bind serial_frame_tx sftx_chk uChk (
  .clk    (clk),
  .rst    (rst),
  .tickEn (tickEn),
  .sendCmd(sendCmd),
  .txLine (txLine),
  .busy   (busy)
);

// File: tb/serial_frame_tx_test.sv
`timescale 1ns/1ps
module serial_frame_tx_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tickEn = 1'b0;
  logic [7:0] dataIn = 8'h00;
  logic       sendCmd = 1'b0;
  logic       txLine;
  logic       busy;

  int checkCnt = 0;
  int failCnt  = 0;
  int tickDiv  = 3;
  int tickPh   = 0;

  always #5 clk = ~clk;

  serial_frame_tx uut (
    .clk    (clk),
    .rst    (rst),
    .tickEn (tickEn),
    .dataIn (dataIn),
    .sendCmd(sendCmd),
    .txLine (txLine),
    .busy   (busy)
  );

  // Oversampling enable, one pulse every tickDiv cycles, changed away from the edge
  always @(negedge clk) begin
    if (tickPh >= tickDiv - 1) begin
      tickPh = 0;
      tickEn = 1'b1;
    end else begin
      tickPh = tickPh + 1;
      tickEn = 1'b0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic waitTicks(input int n);
    for (int k = 0; k < n; k++) begin
      do @(posedge clk); while (!tickEn);
    end
  endtask

  task automatic idleFor(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk({req, " idle busy"}, busy, 0);
      chk({req, " idle line"}, txLine, 1);
    end
  endtask

  // Issue a command and check the whole frame against the requirement model
  task automatic sendFrame(input logic [7:0] d, input bit holdCmd, input string ctx);
    logic bits [11];
    bits[0] = 1'b0;
    for (int i = 0; i < 8; i++) bits[i+1] = d[i];
    bits[9]  = ^d;
    bits[10] = 1'b1;
    @(negedge clk);
    dataIn  = d;
    sendCmd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (!holdCmd) sendCmd = 1'b0;
    chk({"R2 busy on accept ", ctx}, busy, 1);
    for (int i = 0; i < 11; i++) begin
      chk({(i == 9) ? "R5 parity " : "R4 bit start ", ctx}, txLine, bits[i]);
      waitTicks(15);
      @(negedge clk);
      chk({"R3 bit held 15 ticks ", ctx}, txLine, bits[i]);
      if (i < 10) chk({"R3 busy in frame ", ctx}, busy, 1);
      waitTicks(1);
      @(negedge clk);
    end
    chk({"R9 busy low after stop ", ctx}, busy, 0);
    chk({"R9 line high after stop ", ctx}, txLine, 1);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 line in reset", txLine, 1);
    chk("R1 busy in reset", busy, 0);
    rst = 1'b0;
    idleFor(20, "R1");
  endtask

  task automatic t_patterns();
    tickDiv = 3;
    sendFrame(8'hA5, 1'b0, "R4 A5");
    tickDiv = 1;
    sendFrame(8'h00, 1'b0, "R5 00");
    sendFrame(8'hFF, 1'b0, "R5 FF");
    sendFrame(8'h01, 1'b0, "R5 01");
    sendFrame(8'h80, 1'b0, "R4 80");
    tickDiv = 5;
    sendFrame(8'h3C, 1'b0, "R3 slow 3C");
    tickDiv = 3;
  endtask

  task automatic t_held();
    sendFrame(8'h5A, 1'b1, "R7 held");
    idleFor(200, "R7");
    @(negedge clk);
    sendCmd = 1'b0;
    idleFor(2, "R7");
  endtask

  task automatic t_busyIgnore();
    fork
      sendFrame(8'hC3, 1'b0, "R6/R8");
      begin
        repeat (100) @(negedge clk);
        sendCmd = 1'b1;
        dataIn  = 8'h0F;
        repeat (5) @(negedge clk);
        sendCmd = 1'b0;
        repeat (200) @(negedge clk);
        sendCmd = 1'b1;
        dataIn  = 8'hF0;
        @(negedge clk);
        sendCmd = 1'b0;
      end
    join
    idleFor(300, "R8");
  endtask

  task automatic t_backToBack();
    sendFrame(8'h12, 1'b0, "R9 first");
    sendFrame(8'h34, 1'b0, "R9 second");
  endtask

  task automatic t_resetCmd();
    @(negedge clk);
    rst     = 1'b1;
    sendCmd = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idleFor(60, "R10");
    sendCmd = 1'b0;
    idleFor(2, "R10");
    sendFrame(8'h69, 1'b0, "R10 after");
  endtask

  bit finished = 1'b0;

  initial begin
    t_reset();
    t_patterns();
    t_held();
    t_busyIgnore();
    t_backToBack();
    t_resetCmd();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
      $finish;
    end
  end

endmodule